// File: doc/BRIEF.md
# Virtual-Channel Router Input Port with Credit Tracking

This block is the receive side of one router port whose flit storage is split into several independent virtual-channel queues that share one physical link. Every arriving flit names its virtual channel and is appended to that channel's queue. The block shows the oldest flit of every queue, with the output port that its packet asks for, to a switch arbiter outside the block. A dequeue command from the arbiter removes the oldest flit of one channel. In the same cycle the block returns one credit for that channel to the upstream sender. A channel whose oldest flit waits for a busy output never holds up the other channels.

The block also holds the sender-side credit counters for the downstream link. There is one counter per downstream channel, and it counts the free slots that the far end still offers on that channel. A channel may transmit only while its counter is nonzero. Route computation and the crossbar sit outside the block.

Top module: `vcb_input_port`

## Requirements
- R1: After reset every queue is empty (`head_valid` all zero), `wr_err` is low, every sender credit counter reads DEPTH and every `tx_can_send` bit is high.
- R2: A flit presented with `in_valid` is appended to the queue selected by `in_vc`. If that queue was empty, the flit appears on the channel's head outputs in the next cycle with `head_valid` set.
- R3: Each queue holds up to DEPTH flits and delivers them in arrival order. Kind and payload reach the head outputs unchanged.
- R4: Queues are independent. A full or stalled channel does not delay writes to, or dequeues from, any other channel.
- R5: `deq_valid` removes the head of queue `deq_vc` and raises `crd_valid` in the same cycle with `crd_vc` equal to `deq_vc`. A dequeue of an empty channel changes nothing and returns no credit.
- R6: A write to a queue that holds DEPTH flits at the start of the cycle is dropped, even if the same queue is dequeued in that cycle. `wr_err` goes high for exactly the following cycle and the queue contents stay as they were.
- R7: Flit kind encoding: 00 body, 01 head, 10 tail, 11 single-flit packet. When a head or single flit is at the front of a queue, `head_port` shows its payload bits [PORT_W-1:0]. When a body or tail flit is at the front, `head_port` shows the port of the last head or single flit dequeued from that channel, or zero if there has been none since reset.
- R8: `tx_valid` lowers the counter of `tx_vc` by one. `rx_crd_valid` raises the counter of `rx_crd_vc` by one. Both on the same channel in one cycle leave it unchanged. Each `tx_can_send` bit is high exactly when its counter is nonzero.
- R9: A send on a channel whose counter is zero is not counted, so the counter stays at zero. A returned credit on a channel already at DEPTH, without a send in the same cycle, is ignored.
- R10: A write and a dequeue on the same non-full queue in one cycle both take effect, so the occupancy is unchanged and order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | VC_W | Virtual channel of the incoming flit |
| in_kind | input | 2 | Flit kind (R7 encoding) |
| in_data | input | DATA_W | Flit payload; head flits carry the output port in the low PORT_W bits |
| head_valid | output | NUM_VC | Per channel: queue not empty |
| head_kind | output | 2*NUM_VC | Kind of each channel's front flit |
| head_data | output | DATA_W*NUM_VC | Payload of each channel's front flit |
| head_port | output | PORT_W*NUM_VC | Requested output port of each channel |
| deq_valid | input | 1 | Arbiter grant: dequeue one channel |
| deq_vc | input | VC_W | Channel to dequeue |
| crd_valid | output | 1 | Credit returned upstream this cycle |
| crd_vc | output | VC_W | Channel of the returned credit |
| wr_err | output | 1 | Write to a full queue was dropped in the previous cycle |
| tx_valid | input | 1 | A flit is sent downstream this cycle |
| tx_vc | input | VC_W | Channel of the sent flit |
| rx_crd_valid | input | 1 | Credit received from downstream |
| rx_crd_vc | input | VC_W | Channel of the received credit |
| tx_credit | output | CNT_W*NUM_VC | Sender credit count per channel |
| tx_can_send | output | NUM_VC | Per channel: credit count nonzero |

## Verification
Two groups of events can land in the same cycle. The first is a write and a dequeue on one queue. The bench provokes it on a half-filled queue, where occupancy must hold and order must survive. It also provokes it on a full queue, where the write must be dropped and flagged while the dequeue still happens. The second is a downstream send and a returned credit on one channel. The bench forces it at the full count and at zero, and long random runs reach it at every level in between. A bench model of every queue, route latch and counter judges the outputs each cycle.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
   typedef enum logic [1:0] {
      FLIT_BODY = 2'b00,
      FLIT_HEAD = 2'b01,
      FLIT_TAIL = 2'b10,
      FLIT_SOLO = 2'b11
   } flit_kind_e;

   // A flit that starts a packet (head or single) carries the route.
   function automatic logic kind_opens(input logic [1:0] kind);
      return kind[0];
   endfunction
endpackage

// File: rtl/vcb_fifo.sv
module vcb_fifo #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 18,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic             full,
   output logic             nonempty,
   output logic             dropped,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             push_ok, pop_ok;

   if (DEPTH < 2) begin : g_depth_chk
      $error("vcb_fifo: DEPTH must be at least 2");
   end

   assign full     = (count == CNT_W'(DEPTH));
   assign nonempty = (count != '0);
   assign push_ok  = push && !full;
   assign pop_ok   = pop && nonempty;
   assign dropped  = push && full;
   assign rdata    = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= bump(wr_ptr);
         if (pop_ok)  rd_ptr <= bump(rd_ptr);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r10_push_pop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> (count == $past(count)));
   a_r6_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
      (dropped && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/vcb_route_hold.sv
module vcb_route_hold
   import vcb_pkg::*;
#(
   parameter int PORT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              front_valid,
   input  logic [1:0]        front_kind,
   input  logic [PORT_W-1:0] front_port,
   input  logic              pop,
   output logic [PORT_W-1:0] port_o
);
   logic [PORT_W-1:0] route_q;
   logic              front_opens;
   logic              latch_en;

   assign front_opens = front_valid && kind_opens(front_kind);
   assign latch_en    = pop && front_opens;
   assign port_o      = front_opens ? front_port : route_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        route_q <= '0;
      else if (latch_en) route_q <= front_port;
   end

   a_r7_route_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && front_opens) |=> $stable(route_q));
endmodule

// File: rtl/vcb_credit_ctr.sv
module vcb_credit_ctr #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give,
   output logic [CNT_W-1:0] count,
   output logic             nonzero
);
   logic take_eff, give_eff;

   assign nonzero  = (count != '0);
   assign take_eff = take && nonzero;
   assign give_eff = give && ((count != CNT_W'(DEPTH)) || take_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) count <= CNT_W'(DEPTH);
      else begin
         case ({take_eff, give_eff})
            2'b10:   count <= count - CNT_W'(1);
            2'b01:   count <= count + CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r9_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !give) |=> (count == '0));
   a_r8_send_and_return: assert property (@(posedge clk) disable iff (!rst_n)
      (take && give && count != '0) |=> $stable(count));
endmodule

// File: rtl/vcb_input_port.sv
module vcb_input_port
   import vcb_pkg::*;
#(
   parameter int NUM_VC = 4,
   parameter int DEPTH  = 4,
   parameter int DATA_W = 16,
   parameter int PORT_W = 3,
   localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int ENT_W = DATA_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [VC_W-1:0]          in_vc,
   input  logic [1:0]               in_kind,
   input  logic [DATA_W-1:0]        in_data,
   output logic [NUM_VC-1:0]        head_valid,
   output logic [2*NUM_VC-1:0]      head_kind,
   output logic [DATA_W*NUM_VC-1:0] head_data,
   output logic [PORT_W*NUM_VC-1:0] head_port,
   input  logic                     deq_valid,
   input  logic [VC_W-1:0]          deq_vc,
   output logic                     crd_valid,
   output logic [VC_W-1:0]          crd_vc,
   output logic                     wr_err,
   input  logic                     tx_valid,
   input  logic [VC_W-1:0]          tx_vc,
   input  logic                     rx_crd_valid,
   input  logic [VC_W-1:0]          rx_crd_vc,
   output logic [CNT_W*NUM_VC-1:0]  tx_credit,
   output logic [NUM_VC-1:0]        tx_can_send
);
   if (NUM_VC < 2) begin : g_vc_chk
      $error("vcb_input_port: NUM_VC must be at least 2");
   end
   if (PORT_W > DATA_W) begin : g_port_chk
      $error("vcb_input_port: PORT_W must not exceed DATA_W");
   end

   logic [NUM_VC-1:0] push_v, pop_v, drop_v, ret_v;
   logic              wr_err_q;

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic [ENT_W-1:0] front;
      logic             full_w;

      assign push_v[v] = in_valid  && (in_vc  == VC_W'(v));
      assign pop_v[v]  = deq_valid && (deq_vc == VC_W'(v));
      assign ret_v[v]  = pop_v[v] && head_valid[v];

      vcb_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push_v[v]),
         .wdata    ({in_kind, in_data}),
         .pop      (pop_v[v]),
         .full     (full_w),
         .nonempty (head_valid[v]),
         .dropped  (drop_v[v]),
         .rdata    (front)
      );

      assign head_kind[2*v +: 2]         = front[ENT_W-1 -: 2];
      assign head_data[DATA_W*v +: DATA_W] = front[DATA_W-1:0];

      vcb_route_hold #(.PORT_W(PORT_W)) u_route (
         .clk         (clk),
         .rst_n       (rst_n),
         .front_valid (head_valid[v]),
         .front_kind  (front[ENT_W-1 -: 2]),
         .front_port  (front[PORT_W-1:0]),
         .pop         (pop_v[v]),
         .port_o      (head_port[PORT_W*v +: PORT_W])
      );

      vcb_credit_ctr #(.DEPTH(DEPTH)) u_credit (
         .clk     (clk),
         .rst_n   (rst_n),
         .take    (tx_valid && (tx_vc == VC_W'(v))),
         .give    (rx_crd_valid && (rx_crd_vc == VC_W'(v))),
         .count   (tx_credit[CNT_W*v +: CNT_W]),
         .nonzero (tx_can_send[v])
      );

      a_r4_full_blocks_only_self: assert property (@(posedge clk) disable iff (!rst_n)
         (full_w && !pop_v[v]) |=> head_valid[v]);
   end

   assign crd_valid = |ret_v;
   assign crd_vc    = deq_vc;

   always_ff @(posedge clk) begin
      if (!rst_n) wr_err_q <= 1'b0;
      else        wr_err_q <= |drop_v;
   end
   assign wr_err = wr_err_q;

   a_r6_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(in_valid));
   a_r5_single_credit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ret_v));
   a_r5_credit_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      crd_valid |-> (deq_valid && head_valid != '0));
endmodule

// File: tb/vcb_input_port_bench.sv
`timescale 1ns/1ps
module vcb_input_port_bench;
   localparam int NV = 4, DP = 4, DW = 16, PW = 3, VW = 2, CW = 3;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, deq_valid = 0, tx_valid = 0, rx_crd_valid = 0;
   logic [VW-1:0] in_vc = 0, deq_vc = 0, tx_vc = 0, rx_crd_vc = 0;
   logic [1:0] in_kind = 0;
   logic [DW-1:0] in_data = 0;
   logic [NV-1:0] head_valid, tx_can_send;
   logic [2*NV-1:0] head_kind;
   logic [DW*NV-1:0] head_data;
   logic [PW*NV-1:0] head_port;
   logic [CW*NV-1:0] tx_credit;
   logic crd_valid, wr_err;
   logic [VW-1:0] crd_vc;

   always #5 clk = ~clk;

   vcb_input_port #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW), .PORT_W(PW)) u_vcb_input_port (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_kind(in_kind),
      .in_data(in_data), .head_valid(head_valid), .head_kind(head_kind),
      .head_data(head_data), .head_port(head_port), .deq_valid(deq_valid),
      .deq_vc(deq_vc), .crd_valid(crd_valid), .crd_vc(crd_vc), .wr_err(wr_err),
      .tx_valid(tx_valid), .tx_vc(tx_vc), .rx_crd_valid(rx_crd_valid),
      .rx_crd_vc(rx_crd_vc), .tx_credit(tx_credit), .tx_can_send(tx_can_send));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   logic [17:0] mq [NV][DP];
   int          mc [NV];
   int          mcr [NV];
   logic [PW-1:0] mrt [NV];
   logic        merr;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] exp_port(input int v);
      if (mc[v] != 0 && mq[v][0][16]) return mq[v][0][PW-1:0];
      return mrt[v];
   endfunction

   task automatic compare_state();
      for (int v = 0; v < NV; v++) begin
         chk("R2 head_valid", 32'(head_valid[v]), 32'(mc[v] != 0));
         if (mc[v] != 0) begin
            chk("R3 head kind+data", 32'({head_kind[2*v +: 2], head_data[DW*v +: DW]}),
                32'(mq[v][0]));
            chk("R7 head_port", 32'(head_port[PW*v +: PW]), 32'(exp_port(v)));
         end
         chk("R8 credit count", 32'(tx_credit[CW*v +: CW]), 32'(mcr[v]));
         chk("R8 can_send", 32'(tx_can_send[v]), 32'(mcr[v] != 0));
      end
      chk("R6 wr_err", 32'(wr_err), 32'(merr));
   endtask

   // One clock: called and returns at a negative edge.
   task automatic cyc(input bit iv, input int ivc, input logic [1:0] ik, input logic [DW-1:0] id,
                      input bit dv, input int dvc, input bit tv, input int tvc,
                      input bit rv, input int rvc);
      bit drop, popok, te, ge;
      compare_state();
      in_valid = iv; in_vc = VW'(ivc); in_kind = ik; in_data = id;
      deq_valid = dv; deq_vc = VW'(dvc);
      tx_valid = tv; tx_vc = VW'(tvc); rx_crd_valid = rv; rx_crd_vc = VW'(rvc);
      #1;
      popok = dv && mc[dvc] != 0;
      chk("R5 crd_valid", 32'(crd_valid), 32'(popok));
      if (popok) chk("R5 crd_vc", 32'(crd_vc), 32'(dvc));
      drop = iv && mc[ivc] == DP;
      if (popok) begin
         if (mq[dvc][0][16]) mrt[dvc] = mq[dvc][0][PW-1:0];
         for (int i = 0; i < DP - 1; i++) mq[dvc][i] = mq[dvc][i+1];
         mc[dvc]--;
      end
      if (iv && !drop) begin
         mq[ivc][mc[ivc]] = {ik, id};
         mc[ivc]++;
      end
      merr = drop;
      te = tv && mcr[tvc] != 0;
      ge = rv && (mcr[rvc] != DP || (te && tvc == rvc));
      if (te) mcr[tvc]--;
      if (ge) mcr[rvc]++;
      @(posedge clk);
      @(negedge clk);
      in_valid = 0; deq_valid = 0; tx_valid = 0; rx_crd_valid = 0;
   endtask

   task automatic wr(input int v, input logic [1:0] k, input logic [DW-1:0] d);
      cyc(1, v, k, d, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic rd(input int v);
      cyc(0, 0, 2'b00, '0, 1, v, 0, 0, 0, 0);
   endtask

   initial begin
      for (int v = 0; v < NV; v++) begin
         mc[v] = 0; mcr[v] = DP; mrt[v] = '0;
      end
      merr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 head_valid", 32'(head_valid), 0);
      chk("R1 wr_err", 32'(wr_err), 0);
      chk("R1 can_send", 32'(tx_can_send), 32'(4'hF));
      for (int v = 0; v < NV; v++) chk("R1 credit", 32'(tx_credit[CW*v +: CW]), DP);

      // R2/R3/R7: a three-flit packet on VC2 with port 5
      wr(2, 2'b01, 16'hA105);
      chk("R2 flit visible", 32'(head_valid[2]), 1);
      wr(2, 2'b00, 16'hB202);
      wr(2, 2'b10, 16'hC303);
      chk("R7 port from head", 32'(head_port[PW*2 +: PW]), 5);
      rd(2);
      chk("R7 port held on body", 32'(head_port[PW*2 +: PW]), 5);
      chk("R3 order body", 32'(head_data[DW*2 +: DW]), 32'h0000B202);
      rd(2); rd(2);
      // R5: dequeue of an empty VC gives no credit
      rd(2);

      // R6: fill VC1, overfill, then overfill with same-cycle dequeue
      for (int i = 0; i < DP; i++) wr(1, 2'b11, DW'(16'h1100 + i));
      wr(1, 2'b11, 16'hDEAD);
      chk("R6 err after drop", 32'(wr_err), 1);
      cyc(1, 1, 2'b11, 16'hBEEF, 1, 1, 0, 0, 0, 0);
      chk("R6 drop with pop", 32'(head_data[DW*1 +: DW]), 32'h1101);
      // R4: VC1 full and stalled; VC0 still moves
      wr(0, 2'b11, 16'h0007);
      chk("R4 vc0 accepted", 32'(head_valid[0]), 1);
      wr(0, 2'b11, 16'h0006);
      // R10: write and pop on VC0 together
      cyc(1, 0, 2'b11, 16'h0004, 1, 0, 0, 0, 0, 0);
      chk("R10 order kept", 32'(head_data[DW*0 +: DW]), 32'h0006);
      chk("R4 vc1 untouched", 32'(head_data[DW*1 +: DW]), 32'h1101);

      // R8/R9: credits on VC3
      cyc(0, 0, 0, 0, 0, 0, 1, 3, 1, 3);
      chk("R8 send+return at full", 32'(tx_credit[CW*3 +: CW]), DP);
      for (int i = 0; i < DP + 1; i++) cyc(0, 0, 0, 0, 0, 0, 1, 3, 0, 0);
      chk("R9 floor at zero", 32'(tx_credit[CW*3 +: CW]), 0);
      chk("R9 cannot send", 32'(tx_can_send[3]), 0);
      cyc(0, 0, 0, 0, 0, 0, 1, 3, 1, 3);
      chk("R9 send at zero not counted", 32'(tx_credit[CW*3 +: CW]), 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
      chk("R9 return at full ignored", 32'(tx_credit[CW*2 +: CW]), DP);

      // random traffic
      void'($urandom(32'd4711));
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r = $urandom;
         cyc(r[0] | r[1], int'(r[3:2]), r[5:4], DW'($urandom),
             r[6] | r[7], int'(r[9:8]), r[10], int'(r[12:11]), r[13], int'(r[15:14]));
      end
      compare_state();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule